// File: doc/BRIEF.md
# Hub Downstream Port Power Manager

This block switches power to the four downstream ports of a USB hub, drives a connect-status indicator per port, and keeps the overcurrent status and change bits that the hub reports to the host. Each port has an overcurrent input. A raw overcurrent level first passes through a two-flop synchronizer. It is acted on only after it has stayed high for a qualification window of clocks. A qualified overcurrent cuts power to the affected port, or to every port when power control is ganged. It also records a sticky change bit that the hub's request logic later clears.

The hub control logic drives single-cycle set and clear strobes for port power, port enable and the overcurrent change bit. Two configuration inputs choose per-port or ganged behaviour. One applies to power switching and the other applies to overcurrent reporting. A mode strap selects self-powered operation (high) or bus-powered operation (low). In self-powered mode, the local-supply-good input is watched and a low level raises a fault output. In bus-powered mode that input is ignored. All outputs are active-high and are cleared by a synchronous reset.

Top module: `hub_port_power`

## Requirements
- R1: While `rst` is high at a clock edge, `pwr_en`, `conn_stat`, `oc_stat`, `oc_chg` and `lps_fault` are all 0 after that edge.
- R2: An overcurrent is qualified only after `oc_in[i]` has been seen high by the second synchronizer flop on 8 consecutive edges. The qualified effects appear after the 11th rising edge that follows `oc_in[i]` going high. A pulse 7 clocks long has no effect on any output.
- R3: With `pwr_gang`=0, a qualified overcurrent on port i clears `pwr_en[i]` and `conn_stat[i]` and leaves the other ports unchanged.
- R4: With `pwr_gang`=1, a qualified overcurrent on any port clears all bits of `pwr_en`. Any bit of `pwr_set` powers all ports, and any bit of `pwr_clr` unpowers all ports.
- R5: A port cut by overcurrent stays unpowered after the overcurrent ends. A `pwr_set` is ignored while the qualified overcurrent of the port's power group is present. The qualified overcurrent drops on the 3rd edge after `oc_in` falls. A `pwr_set` seen on the 4th edge or later restores power.
- R6: With `oc_gang`=0, `oc_stat[i]` follows the qualified overcurrent of port i. `oc_chg[i]` sets when that overcurrent becomes qualified and stays set until cleared.
- R7: With `oc_gang`=1, every bit of `oc_stat` shows whether any port has a qualified overcurrent, and a new qualification on any port sets every bit of `oc_chg`.
- R8: A pulse on `oc_chg_clr[i]` clears `oc_chg[i]` at the next edge. A new qualification in the same cycle wins and keeps the bit set.
- R9: `conn_stat[i]` is the port's enable state. `en_set[i]` enables a port only if it is already powered, `en_clr[i]` disables it, and losing power disables it.
- R10: `lps_fault` goes high one edge after `self_pwr_mode`=1 with `local_pwr_ok`=0. With `self_pwr_mode`=0 it stays 0 whatever `local_pwr_ok` is.
- R11: With `pwr_gang`=0, `pwr_set[i]` powers port i and `pwr_clr[i]` unpowers it at the next edge. When both are high, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| self_pwr_mode | input | 1 | 1 = self-powered, 0 = bus-powered |
| local_pwr_ok | input | 1 | Local supply good (self-powered only) |
| pwr_gang | input | 1 | 1 = ganged power switching |
| oc_gang | input | 1 | 1 = ganged overcurrent reporting |
| oc_in | input | NPORT | Raw per-port overcurrent levels |
| pwr_set | input | NPORT | Port power on strobes |
| pwr_clr | input | NPORT | Port power off strobes |
| en_set | input | NPORT | Port enable strobes |
| en_clr | input | NPORT | Port disable strobes |
| oc_chg_clr | input | NPORT | Overcurrent change bit clear strobes |
| pwr_en | output | NPORT | Power switch enables |
| conn_stat | output | NPORT | Connect-status indicators |
| oc_stat | output | NPORT | Reported overcurrent status |
| oc_chg | output | NPORT | Reported overcurrent change bits |
| lps_fault | output | 1 | Local supply lost in self-powered mode |

## Verification
Each strobe (power, enable, change-clear) and each strap change is due one edge after it is driven. An overcurrent is due after exactly 11 edges, and its release from `oc_stat` is due after 4 edges. The bench drives every input on a falling edge and counts falling edges before sampling. The overcurrent tests sample one edge early, to confirm that nothing has changed yet, and then on the due edge. The release test drives a power strobe on the 2nd edge after the overcurrent falls, which must be ignored. It then repeats the strobe on the 5th edge, which must take effect.

// File: rtl/hub_port_power.sv
module hub_port_power #(
  parameter int NPORT = 4,
  parameter int QUAL  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             self_pwr_mode,
  input  logic             local_pwr_ok,
  input  logic             pwr_gang,
  input  logic             oc_gang,
  input  logic [NPORT-1:0] oc_in,
  input  logic [NPORT-1:0] pwr_set,
  input  logic [NPORT-1:0] pwr_clr,
  input  logic [NPORT-1:0] en_set,
  input  logic [NPORT-1:0] en_clr,
  input  logic [NPORT-1:0] oc_chg_clr,
  output logic [NPORT-1:0] pwr_en,
  output logic [NPORT-1:0] conn_stat,
  output logic [NPORT-1:0] oc_stat,
  output logic [NPORT-1:0] oc_chg,
  output logic             lps_fault
);
  localparam int CW = $clog2(QUAL + 1);

  logic [NPORT-1:0] sync1, sync2, oc_act, oc_seen;
  logic [NPORT-1:0] pwr_q, en_q, stat_q, chg_q;
  logic             fault_q;

  for (genvar i = 0; i < NPORT; i++) begin : g_qual
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)                    cnt <= '0;
      else if (!sync2[i])         cnt <= '0;
      else if (cnt != CW'(QUAL))  cnt <= cnt + 1'b1;
    end
    assign oc_act[i] = (cnt == CW'(QUAL));
  end

  logic             any_oc, any_rise;
  logic [NPORT-1:0] rise, grp_oc, set_v, clr_v, pwr_nx, en_nx, rep_stat, rep_rise;

  assign any_oc   = |oc_act;
  assign rise     = oc_act & ~oc_seen;
  assign any_rise = |rise;
  assign grp_oc   = pwr_gang ? {NPORT{any_oc}}    : oc_act;
  assign set_v    = pwr_gang ? {NPORT{|pwr_set}}  : pwr_set;
  assign clr_v    = pwr_gang ? {NPORT{|pwr_clr}}  : pwr_clr;
  assign pwr_nx   = ~grp_oc & ~clr_v & (pwr_q | set_v);
  assign en_nx    = pwr_nx & pwr_q & ~en_clr & (en_q | en_set);
  assign rep_stat = oc_gang ? {NPORT{any_oc}}   : oc_act;
  assign rep_rise = oc_gang ? {NPORT{any_rise}} : rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1   <= '0;
      sync2   <= '0;
      oc_seen <= '0;
      pwr_q   <= '0;
      en_q    <= '0;
      stat_q  <= '0;
      chg_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      sync1   <= oc_in;
      sync2   <= sync1;
      oc_seen <= oc_act;
      pwr_q   <= pwr_nx;
      en_q    <= en_nx;
      stat_q  <= rep_stat;
      chg_q   <= rep_rise | (chg_q & ~oc_chg_clr);
      fault_q <= self_pwr_mode & ~local_pwr_ok;
    end
  end

  assign pwr_en    = pwr_q;
  assign conn_stat = en_q;
  assign oc_stat   = stat_q;
  assign oc_chg    = chg_q;
  assign lps_fault = fault_q;
endmodule

module hub_port_power_chk #(
  parameter int NPORT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             pwr_gang,
  input logic             self_pwr_mode,
  input logic [NPORT-1:0] oc_act,
  input logic [NPORT-1:0] pwr_en,
  input logic [NPORT-1:0] conn_stat,
  input logic [NPORT-1:0] oc_chg,
  input logic [NPORT-1:0] oc_chg_clr,
  input logic             lps_fault
);
  a_r9_conn_needs_power: assert property (@(posedge clk) disable iff (rst)
    (conn_stat != '0) |-> ((conn_stat & ~pwr_en) == '0));

  a_r3_oc_cuts_power: assert property (@(posedge clk) disable iff (rst)
    (oc_act != '0) |=> ((pwr_en & $past(oc_act)) == '0));

  a_r4_gang_cuts_all: assert property (@(posedge clk) disable iff (rst)
    (pwr_gang && oc_act != '0) |=> (pwr_en == '0));

  a_r6_chg_sticky: assert property (@(posedge clk) disable iff (rst)
    (oc_chg != '0) |=> ((($past(oc_chg) & ~$past(oc_chg_clr)) & ~oc_chg) == '0));

  a_r10_bus_ignores_supply: assert property (@(posedge clk) disable iff (rst)
    (!self_pwr_mode) |=> !lps_fault);
endmodule

bind hub_port_power hub_port_power_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst(rst), .pwr_gang(pwr_gang), .self_pwr_mode(self_pwr_mode),
  .oc_act(oc_act), .pwr_en(pwr_en), .conn_stat(conn_stat), .oc_chg(oc_chg),
  .oc_chg_clr(oc_chg_clr), .lps_fault(lps_fault)
);

// File: tb/tb_hub_port_power.sv
module tb_hub_port_power;
  localparam time PERIOD = 10ns;
  localparam int  NP = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic self_pwr_mode = 1'b0, local_pwr_ok = 1'b0, pwr_gang = 1'b0, oc_gang = 1'b0;
  logic [NP-1:0] oc_in = '0, pwr_set = '0, pwr_clr = '0, en_set = '0, en_clr = '0, oc_chg_clr = '0;
  logic [NP-1:0] pwr_en, conn_stat, oc_stat, oc_chg;
  logic lps_fault;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  hub_port_power #(.NPORT(NP), .QUAL(8)) dut (
    .clk(clk), .rst(rst), .self_pwr_mode(self_pwr_mode), .local_pwr_ok(local_pwr_ok),
    .pwr_gang(pwr_gang), .oc_gang(oc_gang), .oc_in(oc_in), .pwr_set(pwr_set),
    .pwr_clr(pwr_clr), .en_set(en_set), .en_clr(en_clr), .oc_chg_clr(oc_chg_clr),
    .pwr_en(pwr_en), .conn_stat(conn_stat), .oc_stat(oc_stat), .oc_chg(oc_chg),
    .lps_fault(lps_fault));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic strobe(input int kind, input logic [NP-1:0] v);
    case (kind)
      0: pwr_set = v;
      1: pwr_clr = v;
      2: en_set = v;
      3: en_clr = v;
      default: oc_chg_clr = v;
    endcase
    tick(1);
    pwr_set = '0; pwr_clr = '0; en_set = '0; en_clr = '0; oc_chg_clr = '0;
  endtask

  task automatic t_reset();
    tick(3);
    check("R1 pwr_en", 32'(pwr_en), 0);
    check("R1 conn", 32'(conn_stat), 0);
    check("R1 oc_stat", 32'(oc_stat), 0);
    check("R1 oc_chg", 32'(oc_chg), 0);
    check("R1 lps_fault", 32'(lps_fault), 0);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic t_power();
    strobe(0, 4'b0101);
    check("R11 set", 32'(pwr_en), 32'h5);
    pwr_set = 4'b0001; pwr_clr = 4'b0001; tick(1);
    pwr_set = '0; pwr_clr = '0;
    check("R11 clear wins", 32'(pwr_en), 32'h4);
    strobe(0, 4'b1111);
    check("R11 set all", 32'(pwr_en), 32'hF);
  endtask

  task automatic t_enable();
    strobe(2, 4'b0011);
    check("R9 enable", 32'(conn_stat), 32'h3);
    strobe(1, 4'b0010);
    check("R9 power loss disables", 32'(conn_stat), 32'h1);
    strobe(2, 4'b0010);
    check("R9 unpowered enable ignored", 32'(conn_stat), 32'h1);
    strobe(3, 4'b0001);
    check("R9 disable", 32'(conn_stat), 32'h0);
    strobe(0, 4'b0010);
    strobe(2, 4'b1111);
    check("R9 enable all", 32'(conn_stat), 32'hF);
  endtask

  task automatic t_qual();
    oc_in = 4'b0010; tick(7); oc_in = '0; tick(12);
    check("R2 short pulse pwr", 32'(pwr_en), 32'hF);
    check("R2 short pulse chg", 32'(oc_chg), 32'h0);
    oc_in = 4'b0100; tick(10);
    check("R2 not before 11th edge", 32'(pwr_en), 32'hF);
    tick(1);
    check("R3 port cut", 32'(pwr_en), 32'hB);
    check("R3 conn cut", 32'(conn_stat), 32'hB);
    check("R6 stat", 32'(oc_stat), 32'h4);
    check("R6 chg", 32'(oc_chg), 32'h4);
  endtask

  task automatic t_recover();
    oc_in = '0; tick(1);
    strobe(0, 4'b0100);
    check("R5 set ignored during oc", 32'(pwr_en), 32'hB);
    tick(2);
    check("R6 stat released", 32'(oc_stat), 32'h0);
    check("R5 stays off", 32'(pwr_en), 32'hB);
    check("R6 chg sticky", 32'(oc_chg), 32'h4);
    strobe(0, 4'b0100);
    check("R5 restored", 32'(pwr_en), 32'hF);
  endtask

  task automatic t_chgclr();
    strobe(4, 4'b0100);
    check("R8 clear", 32'(oc_chg), 32'h0);
    oc_in = 4'b0001; tick(10);
    strobe(4, 4'b0001);
    check("R8 set wins", 32'(oc_chg), 32'h1);
    strobe(4, 4'b0001);
    check("R8 clear after", 32'(oc_chg), 32'h0);
    oc_in = '0; tick(4);
    strobe(0, 4'b0001);
    check("R5 restore port0", 32'(pwr_en), 32'hF);
  endtask

  task automatic t_gang_pwr();
    pwr_gang = 1'b1;
    strobe(1, 4'b0001);
    check("R4 gang clear", 32'(pwr_en), 32'h0);
    strobe(0, 4'b0010);
    check("R4 gang set", 32'(pwr_en), 32'hF);
    oc_in = 4'b1000; tick(11);
    check("R4 gang cut", 32'(pwr_en), 32'h0);
    check("R6 indiv report", 32'(oc_chg), 32'h8);
    oc_in = '0; tick(4);
    strobe(4, 4'b1000);
    strobe(0, 4'b0001);
    check("R4 gang restore", 32'(pwr_en), 32'hF);
    pwr_gang = 1'b0;
  endtask

  task automatic t_gang_rep();
    oc_gang = 1'b1;
    oc_in = 4'b0010; tick(11);
    check("R7 gang stat", 32'(oc_stat), 32'hF);
    check("R7 gang chg", 32'(oc_chg), 32'hF);
    check("R3 indiv power", 32'(pwr_en), 32'hD);
    oc_in = '0; tick(4);
    check("R7 gang stat release", 32'(oc_stat), 32'h0);
    strobe(4, 4'b1111);
    strobe(0, 4'b0010);
    oc_gang = 1'b0;
  endtask

  task automatic t_local();
    self_pwr_mode = 1'b0; local_pwr_ok = 1'b0; tick(2);
    check("R10 bus ignores", 32'(lps_fault), 0);
    self_pwr_mode = 1'b1; tick(1);
    check("R10 self fault", 32'(lps_fault), 1);
    local_pwr_ok = 1'b1; tick(1);
    check("R10 self ok", 32'(lps_fault), 0);
    local_pwr_ok = 1'b0; self_pwr_mode = 1'b0; tick(1);
    check("R10 bus again", 32'(lps_fault), 0);
  endtask

  initial begin
    t_reset();
    t_power();
    t_enable();
    t_qual();
    t_recover();
    t_chgclr();
    t_gang_pwr();
    t_gang_rep();
    t_local();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule